// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block sits between program memory and the execute stage of a small microcontroller core. It owns the program counter, which holds a byte address and steps by two for each 16-bit instruction word. Every cycle in which a fetched word is presented, the block classifies it. The word can be a complete single-word instruction, a relative branch, the first half of a two-word operation, or a stray second half. A stray second half is recognised by the value 1111 in its top four bits.

A two-word operation is held until its second word arrives. It is then reported as one operation, carrying both the first word and the 12-bit literal of the second. Absolute jumps and calls load the program counter from a word address split across the two words. A relative branch moves the counter by twice its signed word offset. A conditional skip resolved by the execute stage discards the word presented with it. If the discarded word was the first half of a two-word operation, the orphaned second half that follows runs as a harmless no-op.

All outputs are registered. An operation presented at one clock edge is visible from that edge until the next.

Top module: `twoword_fetch_seq`

## Requirements
- R1: After reset `pc_o` is 000000h and `op_valid` is 0. The first word accepted after reset is treated as a fresh instruction, so a word with top bits 1111 there reports a no-op.
- R2: `pc_o` always has bit 0 clear. Each accepted word (`word_valid`=1) that does not load a new target advances `pc_o` by 2. A cycle with `word_valid`=0 leaves `pc_o` unchanged and gives `op_valid`=0.
- R3: Any fresh, unskipped word that matches none of the patterns in R4, R6 or R7 produces one `op_valid` pulse after the edge with `op_kind`=0, `op_first` equal to the word, `op_second`=0 and `op_target`=0.
- R4: The following first words start a two-word operation:
  - 1100xxxx… for a register move (kind 5);
  - 1110 1110 00xx xxxx for loading a file-select register (kind 6);
  - 1110 110x for a call (kind 3);
  - 1110 1111 for a jump (kind 4).
  The first word gives no `op_valid`. The next accepted word, whatever its value, completes the operation with one pulse carrying the kind, `op_first` equal to the first word and `op_second` equal to bits 11:0 of the second word.
- R5: On completing a call or jump, `pc_o` and `op_target` become the byte address {second[11:0], first[7:0], 0}. For example, EF03h then F000h goes to 000006h. Move and register-load completions advance `pc_o` by 2 and report `op_target`=0.
- R6: A fresh, unskipped word 11010 followed by an 11-bit signed offset is a branch (kind 1). `pc_o` and `op_target` become the branch address plus 2 plus twice the offset, computed modulo 2^21.
- R7: A fresh, unskipped word with top four bits 1111 reports a no-op (kind 7). In that report `op_first` is the word and `op_second` is 0, and `pc_o` advances by 2.
- R8: A fresh word accepted with `skip_req`=1 is discarded: there is no `op_valid`, `pc_o` advances by 2 and no two-word operation is opened. A 1111 word after a skipped first word therefore reports a no-op.
- R9: `skip_req` has no effect in a cycle that carries the second word of a pending two-word operation. The operation still completes as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | A fetched word is present this cycle |
| word_in | input | 16 | Instruction word fetched from address `pc_o` |
| skip_req | input | 1 | Discard the word presented this cycle |
| pc_o | output | 21 | Byte address of the next word to fetch |
| op_valid | output | 1 | One-cycle pulse: a complete operation is reported |
| op_kind | output | 3 | Operation kind code (see requirements) |
| op_first | output | 16 | Single word, or first word of a two-word operation |
| op_second | output | 12 | Literal from the second word, else 0 |
| op_target | output | 21 | Byte target of a jump, call or branch, else 0 |

## Verification
Two functions can collide in a single cycle. In the first, a skip request arrives with a word that would otherwise open a two-word operation or take a branch. In the second, a skip request arrives in the very cycle that a pending second word is consumed. Directed sequences drive both cases, and a random phase with skip requests scattered across all word types drives them again. A behavioural reference model in the bench judges each case on every clock. The skipped first word must leave nothing pending, so the orphaned 1111 word reports a no-op. The skip that lands on a pending second word must be ignored, and the operation must complete with its jump target.

// File: rtl/tw_fetch_pkg.sv
package tw_fetch_pkg;
  localparam int WORD_W = 16;
  localparam int LIT_W  = 12;
  localparam int BR_W   = 11;

  typedef enum logic [2:0] {
    K_SINGLE = 3'd0,
    K_BRANCH = 3'd1,
    K_CALL   = 3'd3,
    K_GOTO   = 3'd4,
    K_MOVE   = 3'd5,
    K_LFSR   = 3'd6,
    K_NOP    = 3'd7
  } op_kind_t;
endpackage

// File: rtl/tw_word_decode.sv
module tw_word_decode
  import tw_fetch_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output op_kind_t          kind,
  output logic              two_word,
  output logic              branch,
  output logic [BR_W-1:0]   br_off
);
  always_comb begin
    kind     = K_SINGLE;
    two_word = 1'b0;
    branch   = 1'b0;
    if (word[15:12] == 4'hF) begin
      kind = K_NOP;
    end else if (word[15:12] == 4'hC) begin
      kind = K_MOVE;
      two_word = 1'b1;
    end else if (word[15:9] == 7'b1110110) begin
      kind = K_CALL;
      two_word = 1'b1;
    end else if (word[15:8] == 8'hEF) begin
      kind = K_GOTO;
      two_word = 1'b1;
    end else if (word[15:6] == 10'b1110111000) begin
      kind = K_LFSR;
      two_word = 1'b1;
    end else if (word[15:11] == 5'b11010) begin
      kind = K_BRANCH;
      branch = 1'b1;
    end
  end

  assign br_off = word[BR_W-1:0];
endmodule

// File: rtl/tw_pc_unit.sv
module tw_pc_unit #(
  parameter int PC_W = 21
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            load,
  input  logic [PC_W-1:0] load_val,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  always_ff @(posedge clk) begin
    if (rst)
      pc <= '0;
    else if (adv)
      pc <= load ? load_val : pc + STEP;
  end

  assert_pc_even_R2: assert property (@(posedge clk) disable iff (rst)
    pc[0] == 1'b0);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> pc == $past(pc) + STEP);

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pc));
endmodule

// File: rtl/twoword_fetch_seq.sv
module twoword_fetch_seq
  import tw_fetch_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  input  logic              skip_req,
  output logic [PC_W-1:0]   pc_o,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [WORD_W-1:0] op_first,
  output logic [LIT_W-1:0]  op_second,
  output logic [PC_W-1:0]   op_target
);
  localparam int PAD_W = PC_W - BR_W - 1;

  op_kind_t          d_kind;
  logic              d_two, d_branch;
  logic [BR_W-1:0]   d_off;

  logic              pending_q;
  logic [WORD_W-1:0] first_q;
  op_kind_t          first_kind_q;

  logic              second_now, take_fresh, start_two;
  logic              jump_abs, jump_rel, load_pc;
  logic [PC_W-1:0]   abs_tgt, rel_tgt, disp, new_tgt;

  tw_word_decode i_dec (
    .word     (word_in),
    .kind     (d_kind),
    .two_word (d_two),
    .branch   (d_branch),
    .br_off   (d_off)
  );

  assign second_now = word_valid && pending_q;
  assign take_fresh = word_valid && !pending_q && !skip_req;
  assign start_two  = take_fresh && d_two;
  assign jump_abs   = second_now && (first_kind_q == K_CALL || first_kind_q == K_GOTO);
  assign jump_rel   = take_fresh && d_branch;
  assign load_pc    = jump_abs || jump_rel;

  assign abs_tgt = PC_W'({word_in[LIT_W-1:0], first_q[7:0], 1'b0});
  assign disp    = {{PAD_W{d_off[BR_W-1]}}, d_off, 1'b0};
  assign rel_tgt = pc_o + PC_W'(2) + disp;
  assign new_tgt = jump_abs ? abs_tgt : rel_tgt;

  tw_pc_unit #(.PC_W(PC_W)) i_pc (
    .clk      (clk),
    .rst      (rst),
    .adv      (word_valid),
    .load     (load_pc),
    .load_val (new_tgt),
    .pc       (pc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q    <= 1'b0;
      first_q      <= '0;
      first_kind_q <= K_SINGLE;
    end else if (word_valid) begin
      pending_q <= start_two;
      if (start_two) begin
        first_q      <= word_in;
        first_kind_q <= d_kind;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid  <= 1'b0;
      op_kind   <= '0;
      op_first  <= '0;
      op_second <= '0;
      op_target <= '0;
    end else begin
      op_valid <= second_now || (take_fresh && !d_two);
      if (second_now) begin
        op_kind   <= first_kind_q;
        op_first  <= first_q;
        op_second <= word_in[LIT_W-1:0];
        op_target <= jump_abs ? abs_tgt : '0;
      end else if (take_fresh && !d_two) begin
        op_kind   <= d_kind;
        op_first  <= word_in;
        op_second <= '0;
        op_target <= jump_rel ? rel_tgt : '0;
      end
    end
  end

  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (rst)
    !word_valid |=> !op_valid);

  assert_first_silent_R4: assert property (@(posedge clk) disable iff (rst)
    start_two |=> !op_valid && pending_q);

  assert_second_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    second_now |=> op_valid && op_kind == $past(first_kind_q) && !pending_q);

  assert_skip_discard_R8: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !pending_q && skip_req) |=> !op_valid && !pending_q);

  assert_nop_no_load_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd7) |-> op_target == '0 && op_second == '0);
endmodule

// File: tb/test_twoword_fetch_seq.sv
module test_twoword_fetch_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic [15:0] word_in = '0;
  logic        skip_req = 1'b0;
  logic [20:0] pc_o, op_target;
  logic        op_valid;
  logic [2:0]  op_kind;
  logic [15:0] op_first;
  logic [11:0] op_second;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [20:0] m_pc = '0;
  bit          m_pend = 1'b0;
  logic [15:0] m_first = '0;
  bit          e_valid;
  int          e_kind;
  logic [15:0] e_first;
  logic [11:0] e_second;
  logic [20:0] e_target;

  always #5 clk = ~clk;

  twoword_fetch_seq i_twoword_fetch_seq (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
    .skip_req(skip_req), .pc_o(pc_o), .op_valid(op_valid), .op_kind(op_kind),
    .op_first(op_first), .op_second(op_second), .op_target(op_target)
  );

  function automatic int kind_of(input logic [15:0] w);
    if (w[15:12] == 4'hF) return 7;
    if (w[15:12] == 4'hC) return 5;
    if (w[15:9] == 7'b1110110) return 3;
    if (w[15:8] == 8'hEF) return 4;
    if (w[15:6] == 10'b1110111000) return 6;
    if (w[15:11] == 5'b11010) return 1;
    return 0;
  endfunction

  task automatic model(input bit v, input logic [15:0] w, input bit s);
    int k, off;
    e_valid = 1'b0;
    if (!v) return;
    if (m_pend) begin
      k = kind_of(m_first);
      e_valid = 1'b1; e_kind = k; e_first = m_first; e_second = w[11:0];
      e_target = '0;
      m_pend = 1'b0;
      if (k == 3 || k == 4) begin
        e_target = {w[11:0], m_first[7:0], 1'b0};
        m_pc = e_target;
      end else m_pc = m_pc + 21'd2;
    end else if (s) begin
      m_pc = m_pc + 21'd2;
    end else begin
      k = kind_of(w);
      if (k >= 3 && k <= 6) begin
        m_pend = 1'b1; m_first = w; m_pc = m_pc + 21'd2;
      end else begin
        e_valid = 1'b1; e_kind = k; e_first = w; e_second = '0; e_target = '0;
        if (k == 1) begin
          off = int'(w[10:0]);
          if (off >= 1024) off = off - 2048;
          e_target = 21'(int'(m_pc) + 2 + 2 * off);
          m_pc = e_target;
        end else m_pc = m_pc + 21'd2;
      end
    end
  endtask

  task automatic check(input string tag);
    bit ok;
    checks++;
    ok = (pc_o == m_pc) && (op_valid == e_valid);
    if (e_valid)
      ok = ok && (op_kind == 3'(e_kind)) && (op_first == e_first) &&
           (op_second == e_second) && (op_target == e_target);
    if (!ok) begin
      fails++;
      $display("FAIL %s: pc=%h v=%0d k=%0d f=%h s=%h t=%h expected pc=%h v=%0d k=%0d f=%h s=%h t=%h",
               tag, pc_o, op_valid, op_kind, op_first, op_second, op_target,
               m_pc, e_valid, e_kind, e_first, e_second, e_target);
    end
  endtask

  task automatic step(input bit v, input logic [15:0] w, input bit s, input string tag);
    @(negedge clk);
    word_valid = v; word_in = w; skip_req = s;
    model(v, w, s);
    @(posedge clk);
    #2;
    check(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    e_valid = 1'b0;
    check("R1");
    step(1, 16'hF000, 0, "R1");
    step(1, 16'h0E55, 0, "R3");
    step(0, 16'h1234, 0, "R2");
    step(1, 16'h2400, 0, "R3");
    step(1, 16'hC123, 0, "R4");
    step(1, 16'hF456, 0, "R4");
    step(1, 16'hEE12, 0, "R4");
    step(1, 16'hF0AB, 0, "R5");
    step(1, 16'hEF03, 0, "R5");
    step(0, 16'h0000, 0, "R2");
    step(1, 16'hF000, 0, "R5");
    step(1, 16'hED12, 0, "R5");
    step(1, 16'hF345, 0, "R5");
    step(1, 16'hF777, 0, "R7");
    step(1, 16'hC123, 1, "R8");
    step(1, 16'hF456, 0, "R8");
    step(1, 16'hD005, 1, "R8");
    step(1, 16'hEF10, 0, "R9");
    step(1, 16'hF002, 1, "R9");
    step(1, 16'hD003, 0, "R6");
    step(1, 16'hD7FF, 0, "R6");
    step(1, 16'hEF00, 0, "R5");
    step(1, 16'hF000, 0, "R5");
    step(1, 16'hD7FD, 0, "R6");
    step(1, 16'hD402, 0, "R6");
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      int sel;
      sel = $urandom_range(0, 7);
      w = 16'($urandom);
      case (sel)
        0: w[15:12] = 4'hF;
        1: w[15:12] = 4'hC;
        2: w[15:8]  = 8'hEF;
        3: w[15:9]  = 7'b1110110;
        4: w[15:6]  = 10'b1110111000;
        5: w[15:11] = 5'b11010;
        default: ;
      endcase
      step($urandom_range(0, 5) != 0, w, $urandom_range(0, 3) == 0, "R2");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule